// File: doc/BRIEF.md
# Top-Four Ascending Partial Sorter

The block receives a set of eight unsigned keys on one wide bus and returns the four largest keys of that set in ascending order. Internally it is a compare-and-exchange network with one register after every stage. Three stages build two sorted runs of four keys, one ascending and one descending. A fourth stage of max-only cells keeps the larger key of each pair taken across the two runs. The four survivors form a bitonic sequence. Two further ascending merge stages put them in order. After the fourth stage a tap shows the unordered winning set.

Both data edges use valid/ready handshakes. A set is taken on a rising clock edge where `in_valid` and `in_ready` are both high. A result leaves on an edge where `out_valid` and `out_ready` are both high. The whole pipeline moves as one unit. It stalls only while the output register holds a result that the sink has not taken, so `in_ready` equals `!out_valid || out_ready`. While the sink keeps `out_ready` high, the block takes a new set on every clock.

Top module: `psort_top4_bitonic`

## Requirements
- R1: While `out_valid` is high, `out_data` holds the four largest keys of the matching input set. Key j of an input set sits at `in_data[j*KEY_W +: KEY_W]`. Output lane i at `out_data[i*KEY_W +: KEY_W]` carries the (i+1)-th smallest of the four, so lane 0 holds the smallest and lane 3 the largest.
- R2: With no back-pressure, a set taken on clock edge k appears with `out_valid` high right after edge k+5. `out_valid` is still low after edge k+4.
- R3: While `out_ready` stays high, `in_ready` stays high. Sets presented on consecutive cycles come out on consecutive cycles, in the order they were taken.
- R4: `tap_valid` rises right after edge k+3 for a set taken on edge k. `tap_data` then holds the same four keys as the final result, in no guaranteed lane order.
- R5: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` and `out_valid` do not change.
- R6: A set presented while `in_valid` is low, or while `in_ready` is low, produces no output.
- R7: Duplicate keys are kept with their true multiplicity. When keys are equal, the cells leave them in place.
- R8: While `rst_n` is low, `out_valid` and `tap_valid` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input set is present |
| in_ready | output | 1 | Block can take a set this cycle |
| in_data | input | 8*KEY_W | Eight unsigned keys, key j at bits j*KEY_W |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Sink takes the result this cycle |
| out_data | output | 4*KEY_W | Four largest keys, ascending from lane 0 |
| tap_valid | output | 1 | Unordered winning set is present |
| tap_data | output | 4*KEY_W | Four largest keys after selection, any order |

## Verification
The hardest case to reach is a full pipeline frozen by back-pressure. To get there, six sets have to be in flight while the sink refuses. Then a seventh set has to be offered and must be turned away, and every held set must still come out intact once the sink resumes. The stimulus drops `out_ready`, pushes sets back to back until `in_ready` falls, and keeps offering a distinct set while stalled. It then releases the sink and compares each result, in order, against a reference sort computed in the bench. Ties, including a run where every key is equal, come from table rows built to put equal keys on both sides of each selection pair.

// File: rtl/psort_pkg.sv
package psort_pkg;

  // Direction of a compare-and-exchange cell: UP puts the smaller key on
  // the lower lane, DOWN puts the larger key there.
  typedef enum logic {
    CAE_UP   = 1'b0,
    CAE_DOWN = 1'b1
  } cae_dir_e;

  localparam int NET_IN       = 8;
  localparam int NET_SEL      = NET_IN / 2;
  localparam int BUILD_STAGES = 3;
  localparam int SEL_STAGES   = BUILD_STAGES + 1;
  localparam int MERGE_STAGES = 2;
  localparam int PIPE_DEPTH   = SEL_STAGES + MERGE_STAGES;

endpackage

// File: rtl/psort_cae.sv
module psort_cae #(
  parameter int                  W   = 16,
  parameter psort_pkg::cae_dir_e DIR = psort_pkg::CAE_UP
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);

  logic swap;

  generate
    if (DIR == psort_pkg::CAE_UP) begin : g_up
      // Exchange only on strict disorder; equal keys stay put.
      assign swap = (a > b);
    end else begin : g_down
      assign swap = (b > a);
    end
  endgenerate

  assign lo = swap ? b : a;
  assign hi = swap ? a : b;

endmodule

// File: rtl/psort_max.sv
module psort_max #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  // Single comparator steering one multiplexer; ties keep a.
  assign y = (b > a) ? b : a;

endmodule

// File: rtl/psort_pipe_reg.sv
module psort_pipe_reg #(
  parameter int W     = 16,
  parameter int LANES = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        in_v,
  input  logic [LANES-1:0][W-1:0]     in_d,
  output logic                        out_v,
  output logic [LANES-1:0][W-1:0]     out_d
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v <= 1'b0;
      out_d <= '0;
    end else if (en) begin
      out_v <= in_v;
      out_d <= in_d;
    end
  end

  // R5: a frozen stage keeps both its flag and its keys.
  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_v) && $stable(out_d)));

endmodule

// File: rtl/psort_top4_bitonic.sv
module psort_top4_bitonic #(
  parameter int KEY_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [8*KEY_W-1:0]   in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [4*KEY_W-1:0]   out_data,
  output logic                 tap_valid,
  output logic [4*KEY_W-1:0]   tap_data
);

  import psort_pkg::*;

  localparam int NI   = NET_IN;
  localparam int NS   = NET_SEL;
  localparam int HALF = NI / 2;

  logic adv;

  logic [NI-1:0][KEY_W-1:0] x0;
  logic [NI-1:0][KEY_W-1:0] c1, r1, c2, r2, c3, r3;
  logic [NS-1:0][KEY_W-1:0] c4, r4, c5, r5, c6, r6;
  logic v1, v2, v3, v4, v5, v6;

  // Whole pipe advances unless the output holds an untaken result.
  assign adv      = !v6 || out_ready;
  assign in_ready = adv;

  generate
    for (genvar j = 0; j < NI; j++) begin : g_unpack
      assign x0[j] = in_data[j*KEY_W +: KEY_W];
    end

    // Stage 1: two-key merges, alternating direction pair by pair.
    for (genvar p = 0; p < NI/2; p++) begin : g_s1
      psort_cae #(.W(KEY_W), .DIR((p % 2 == 0) ? CAE_UP : CAE_DOWN)) u_cae (
        .a(x0[2*p]), .b(x0[2*p+1]), .lo(c1[2*p]), .hi(c1[2*p+1]));
    end

    // Stages 2 and 3: four-key merges; lower group ascending, upper descending.
    for (genvar g = 0; g < 2; g++) begin : g_grp
      for (genvar i = 0; i < 2; i++) begin : g_s2
        psort_cae #(.W(KEY_W), .DIR((g == 0) ? CAE_UP : CAE_DOWN)) u_cae (
          .a(r1[4*g+i]), .b(r1[4*g+i+2]), .lo(c2[4*g+i]), .hi(c2[4*g+i+2]));
      end
      for (genvar i = 0; i < 2; i++) begin : g_s3
        psort_cae #(.W(KEY_W), .DIR((g == 0) ? CAE_UP : CAE_DOWN)) u_cae (
          .a(r2[4*g+2*i]), .b(r2[4*g+2*i+1]), .lo(c3[4*g+2*i]), .hi(c3[4*g+2*i+1]));
      end
    end

    // Stage 4: half-cleaner with max-only cells keeps the top half.
    for (genvar i = 0; i < NS; i++) begin : g_s4
      psort_max #(.W(KEY_W)) u_max (.a(r3[i]), .b(r3[i+HALF]), .y(c4[i]));
    end

    // Stages 5 and 6: ascending merge of the bitonic survivors.
    for (genvar i = 0; i < 2; i++) begin : g_s5
      psort_cae #(.W(KEY_W), .DIR(CAE_UP)) u_cae (
        .a(r4[i]), .b(r4[i+2]), .lo(c5[i]), .hi(c5[i+2]));
    end
    for (genvar i = 0; i < 2; i++) begin : g_s6
      psort_cae #(.W(KEY_W), .DIR(CAE_UP)) u_cae (
        .a(r5[2*i]), .b(r5[2*i+1]), .lo(c6[2*i]), .hi(c6[2*i+1]));
    end

    for (genvar i = 0; i < NS; i++) begin : g_pack
      assign out_data[i*KEY_W +: KEY_W] = r6[i];
      assign tap_data[i*KEY_W +: KEY_W] = r4[i];
    end
  endgenerate

  psort_pipe_reg #(.W(KEY_W), .LANES(NI)) u_reg1 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(in_valid), .in_d(c1), .out_v(v1), .out_d(r1));
  psort_pipe_reg #(.W(KEY_W), .LANES(NI)) u_reg2 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(v1), .in_d(c2), .out_v(v2), .out_d(r2));
  psort_pipe_reg #(.W(KEY_W), .LANES(NI)) u_reg3 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(v2), .in_d(c3), .out_v(v3), .out_d(r3));
  psort_pipe_reg #(.W(KEY_W), .LANES(NS)) u_reg4 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(v3), .in_d(c4), .out_v(v4), .out_d(r4));
  psort_pipe_reg #(.W(KEY_W), .LANES(NS)) u_reg5 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(v4), .in_d(c5), .out_v(v5), .out_d(r5));
  psort_pipe_reg #(.W(KEY_W), .LANES(NS)) u_reg6 (
    .clk(clk), .rst_n(rst_n), .en(adv), .in_v(v5), .in_d(c6), .out_v(v6), .out_d(r6));

  assign out_valid = v6;
  assign tap_valid = v4;

  // R1: the result leaves in ascending lane order.
  assert_sorted_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v6 |-> (r6[0] <= r6[1] && r6[1] <= r6[2] && r6[2] <= r6[3]));

  // R1: after the build stages the two halves form opposite sorted runs.
  assert_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> (r3[0] <= r3[1] && r3[1] <= r3[2] && r3[2] <= r3[3] &&
            r3[4] >= r3[5] && r3[5] >= r3[6] && r3[6] >= r3[7]));

  // R5: a refused result stays on the output unchanged.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/psort_top4_bitonic_tb_top.sv
module psort_top4_bitonic_tb_top;

  localparam int KW = 16;
  localparam int NROW = 7;

  localparam logic [KW-1:0] TV_IN [NROW][8] = '{
    '{16'd3, 16'd1, 16'd4, 16'd1, 16'd5, 16'd9, 16'd2, 16'd6},
    '{16'd10, 16'd20, 16'd30, 16'd40, 16'd50, 16'd60, 16'd70, 16'd80},
    '{16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10},
    '{16'd7, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7, 16'd7},
    '{16'd5, 16'd9, 16'd9, 16'd1, 16'd9, 16'd2, 16'd9, 16'd3},
    '{16'hFFFF, 16'd0, 16'hFFFF, 16'd0, 16'd1, 16'hFFFE, 16'd0, 16'd2},
    '{16'd7, 16'd7, 16'd3, 16'd3, 16'd8, 16'd8, 16'd1, 16'd1}
  };
  localparam logic [KW-1:0] TV_EXP [NROW][4] = '{
    '{16'd4, 16'd5, 16'd6, 16'd9},
    '{16'd50, 16'd60, 16'd70, 16'd80},
    '{16'd50, 16'd60, 16'd70, 16'd80},
    '{16'd7, 16'd7, 16'd7, 16'd7},
    '{16'd9, 16'd9, 16'd9, 16'd9},
    '{16'd2, 16'hFFFE, 16'hFFFF, 16'hFFFF},
    '{16'd7, 16'd7, 16'd8, 16'd8}
  };

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, out_valid, out_ready, tap_valid;
  logic [8*KW-1:0] in_data;
  logic [4*KW-1:0] out_data, tap_data;

  int n_checks = 0, n_fail = 0, n_push = 0, n_pop = 0, stall_cnt = 0;
  logic [4*KW-1:0] exp_mem [0:63];

  always #10 clk = ~clk;

  psort_top4_bitonic #(.KEY_W(KW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .tap_valid(tap_valid), .tap_data(tap_data));

  function automatic logic [4*KW-1:0] ref_top4(input logic [8*KW-1:0] d);
    logic [KW-1:0] a [8];
    logic [KW-1:0] t;
    logic [4*KW-1:0] r;
    for (int i = 0; i < 8; i++) a[i] = d[i*KW +: KW];
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < 4; i++) r[i*KW +: KW] = a[4+i];
    return r;
  endfunction

  function automatic logic [4*KW-1:0] sort4(input logic [4*KW-1:0] d);
    logic [KW-1:0] a [4];
    logic [KW-1:0] t;
    logic [4*KW-1:0] r;
    for (int i = 0; i < 4; i++) a[i] = d[i*KW +: KW];
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 3 - i; j++)
        if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
    for (int i = 0; i < 4; i++) r[i*KW +: KW] = a[i];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [4*KW-1:0] act, input logic [4*KW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [8*KW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) begin stall_cnt++; @(negedge clk); end
    exp_mem[n_push] = ref_top4(d);
    n_push++;
    @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  // Output monitor: every transfer is compared in order with the reference.
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      chk("R1 R3 stream order", out_data, exp_mem[n_pop]);
      n_pop++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R3 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [8*KW-1:0] d;
    logic [4*KW-1:0] e, snap;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset out_valid", {63'd0, out_valid}, '0);
    chk("R8 reset tap_valid", {63'd0, tap_valid}, '0);
    chk("R8 reset in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    // Table walk: latency, tap and final result per row.
    for (int r = 0; r < NROW; r++) begin
      for (int j = 0; j < 8; j++) d[j*KW +: KW] = TV_IN[r][j];
      for (int j = 0; j < 4; j++) e[j*KW +: KW] = TV_EXP[r][j];
      push(d);
      @(negedge clk); in_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R4 tap not yet valid", {63'd0, tap_valid}, '0);
      @(posedge clk); @(negedge clk);
      chk("R4 tap valid", {63'd0, tap_valid}, 64'd1);
      chk("R4 R7 tap set", sort4(tap_data), e);
      @(posedge clk); @(negedge clk);
      chk("R2 out not yet valid", {63'd0, out_valid}, '0);
      @(posedge clk); @(negedge clk);
      chk("R2 out valid", {63'd0, out_valid}, 64'd1);
      chk("R1 R7 table result", out_data, e);
      @(posedge clk);
    end

    // Back-to-back stream with an always-ready sink.
    stall_cnt = 0;
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 8; j++)
        d[j*KW +: KW] = 16'((i * 977 + j * 4099 + (i ^ j) * 61) % 300);
      push(d);
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R3 no stalls", 64'(stall_cnt), '0);
    chk("R3 all results out", 64'(n_pop), 64'(n_push));

    // Back-pressure: fill the frozen pipe, offer an extra set, then drain.
    out_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) d[j*KW +: KW] = 16'(1000 + i * 50 + j * 7);
      push(d);
    end
    @(negedge clk);
    chk("R5 stalled out_valid", {63'd0, out_valid}, 64'd1);
    chk("R5 stalled in_ready", {63'd0, in_ready}, '0);
    chk("R5 oldest result held", out_data, exp_mem[n_push-6]);
    snap = out_data;
    in_valid = 1'b1;
    in_data = {8{16'hBEEF}};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 in_ready low while stalled", {63'd0, in_ready}, '0);
    end
    chk("R5 output stable", out_data, snap);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R6 refused set not produced", 64'(n_pop), 64'(n_push));
    chk("R6 pipe empty", {63'd0, out_valid}, '0);

    // Changing data with in_valid low must produce nothing.
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_data = {8{16'(i * 111)}};
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6 idle data ignored out", {63'd0, out_valid}, '0);
    chk("R6 idle data ignored tap", {63'd0, tap_valid}, '0);
    chk("R6 idle no transfers", 64'(n_pop), 64'(n_push));

    finish_run();
  end

endmodule